// File: doc/BRIEF.md
# Reset Strap Sampler and Address Pad Controller

This block sits between two shared external memory address pads and the core. While the active-low reset is held, neither pad is driven. The polarity pad (pad 0) gets a weak pull-up and the clock-mode pad (pad 1) gets a weak pull-down. This lets external resistors or the default pulls set a configuration level on each pad, and the block samples that level through a two-flop synchronizer.

When reset is released, the block keeps the last synchronized level of each pad as a strap value. It then turns both pulls off and gives the pads back to the address bits supplied by the core. The polarity strap sets the level of the infrared LED drive. The clock-mode strap selects crystal operation (0, 24 MHz only) or an external clock source (1, 24 MHz or 48 MHz). In external mode, pad 1 is released to high impedance while the core is idle and asleep with interrupt 2 inactive.

Top module: `strap_pad_ctrl`

## Requirements
- R1: While rst_n is 0, pad_oe is 2'b00 and pad_do is 2'b00.
- R2: While rst_n is 0, pad_pu is 2'b01 (pull-up on pad 0 only) and pad_pd is 2'b10 (pull-down on pad 1 only).
- R3: While rst_n is 1, pad_pu and pad_pd are 2'b00 and pad_do equals addr_bits (bit 0 to pad 0, bit 1 to pad 1).
- R4: The held strap values equal the pad levels after two synchronizer flops at the last rising clock edge with rst_n at 0. Any pad level held for at least three cycles before release is captured.
- R5: Pad activity while rst_n is 1 does not change ext_clk_mode or ir_active_high.
- R6: ext_clk_mode equals the held pad 1 strap: 0 means crystal, 1 means external clock.
- R7: With ext_clk_mode at 0 and rst_n at 1, pad_oe is 2'b11 for every combination of cpu_idle, irq2_active and sleep_req.
- R8: With ext_clk_mode at 1 and rst_n at 1, pad_oe[1] is 0 exactly when cpu_idle is 1, irq2_active is 0 and sleep_req is 1. pad_oe[0] stays 1.
- R9: ir_active_high equals the held pad 0 strap. ir_tx_out equals ir_tx_raw when it is 1 and the inverse of ir_tx_raw when it is 0.
- R10: Every new reset assertion samples the straps again, replacing the values held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, also the strap sampling window |
| pad_in | input | 2 | Levels read back from the two pads |
| addr_bits | input | 2 | Core address bits to place on the pads |
| cpu_idle | input | 1 | Core idle flag |
| irq2_active | input | 1 | Interrupt 2 asserted |
| sleep_req | input | 1 | Clock-control sleep flag |
| ir_tx_raw | input | 1 | Infrared transmit data before polarity |
| pad_oe | output | 2 | Per-pad output enable |
| pad_do | output | 2 | Per-pad output data |
| pad_pu | output | 2 | Per-pad weak pull-up enable |
| pad_pd | output | 2 | Per-pad weak pull-down enable |
| ext_clk_mode | output | 1 | Held clock-mode strap |
| ir_active_high | output | 1 | Held polarity strap |
| ir_tx_out | output | 1 | Infrared transmit data after polarity |

## Verification
The hardest case to reach is the power-state park of pad 1. It needs external clock mode, which can only come from a strap sampled during reset. So the bench resets the block once for each of the four strap combinations, holding the pad levels through the reset window. After each release it inverts the pads and sweeps all sixteen combinations of idle, interrupt, sleep and transmit data. This shows that parking happens only in external mode and only for the single idle-asleep-quiet combination, and that the held straps ignore the inverted pads.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned NUM_PADS = 2;
  localparam int unsigned POL_PAD  = 0;
  localparam int unsigned CLK_PAD  = 1;

  // Pad 1 may float only when the core is idle, asleep and interrupt 2 is quiet.
  function automatic logic park_allowed(input logic idle, input logic irq2, input logic sleep);
    return idle & ~irq2 & sleep;
  endfunction

  // Strap 1: LED driven active high; strap 0: data inverted.
  function automatic logic ir_polarize(input logic raw, input logic active_high);
    return active_high ? raw : ~raw;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_lvl,
  output logic [WIDTH-1:0] strap_q,
  output logic             sampling
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= pad_lvl;

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign sampling = ~rst_n;

  // Follow the synchronized level throughout reset; freeze once released.
  always_ff @(posedge clk) begin
    if (sampling) strap_q <= stage_q[STAGES-1];
  end
endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl #(
  parameter bit PULL_UP  = 1'b1,
  parameter bit PARKABLE = 1'b0
) (
  input  logic rst_n,
  input  logic addr_bit,
  input  logic park_req,
  output logic oe,
  output logic dout,
  output logic pu,
  output logic pd
);
  logic park_ok;

  assign park_ok = PARKABLE ? park_req : 1'b0;
  assign oe      = rst_n & ~park_ok;
  assign dout    = rst_n & addr_bit;
  assign pu      = PULL_UP  & ~rst_n;
  assign pd      = ~PULL_UP & ~rst_n;
endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [NUM_PADS-1:0] addr_bits,
  input  logic                cpu_idle,
  input  logic                irq2_active,
  input  logic                sleep_req,
  input  logic                ir_tx_raw,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_do,
  output logic [NUM_PADS-1:0] pad_pu,
  output logic [NUM_PADS-1:0] pad_pd,
  output logic                ext_clk_mode,
  output logic                ir_active_high,
  output logic                ir_tx_out
);
  logic [NUM_PADS-1:0] strap_q;
  logic                sampling;
  logic                park_evt;

  strap_capture #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_lvl  (pad_in),
    .strap_q  (strap_q),
    .sampling (sampling)
  );

  assign ext_clk_mode   = strap_q[CLK_PAD];
  assign ir_active_high = strap_q[POL_PAD];
  assign park_evt       = rst_n & ext_clk_mode & park_allowed(cpu_idle, irq2_active, sleep_req);
  assign ir_tx_out      = ir_polarize(ir_tx_raw, ir_active_high);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pad_ctrl #(
      .PULL_UP  (p == POL_PAD),
      .PARKABLE (p == CLK_PAD)
    ) u_pad (
      .rst_n    (rst_n),
      .addr_bit (addr_bits[p]),
      .park_req (park_evt),
      .oe       (pad_oe[p]),
      .dout     (pad_do[p]),
      .pu       (pad_pu[p]),
      .pd       (pad_pd[p])
    );
  end
endmodule

module strap_pad_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pad_oe,
  input logic [1:0] pad_do,
  input logic [1:0] pad_pu,
  input logic [1:0] pad_pd,
  input logic [1:0] addr_bits,
  input logic       cpu_idle,
  input logic       irq2_active,
  input logic       sleep_req,
  input logic       ir_tx_raw,
  input logic       ext_clk_mode,
  input logic       ir_active_high,
  input logic       ir_tx_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_NO_DRIVE: assert (pad_oe == 2'b00 && pad_do == 2'b00); // R1
      AST_RST_PULLS: assert (pad_pu == 2'b01 && pad_pd == 2'b10); // R2
    end else begin
      AST_RUN_NO_PULLS: assert (pad_pu == 2'b00 && pad_pd == 2'b00 && pad_do == addr_bits); // R3
    end
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(ext_clk_mode) && $stable(ir_active_high))); // R5
  AST_XTAL_NO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_clk_mode |-> pad_oe == 2'b11); // R7
  AST_EXT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_mode && cpu_idle && !irq2_active && sleep_req) |-> pad_oe == 2'b01); // R8
  AST_EXT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_idle && !irq2_active && sleep_req) |-> pad_oe == 2'b11); // R8
  AST_IR_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ir_tx_out == (ir_tx_raw ~^ ir_active_high)); // R9
endmodule

bind strap_pad_ctrl strap_pad_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
  .pad_pd(pad_pd), .addr_bits(addr_bits), .cpu_idle(cpu_idle),
  .irq2_active(irq2_active), .sleep_req(sleep_req), .ir_tx_raw(ir_tx_raw),
  .ext_clk_mode(ext_clk_mode), .ir_active_high(ir_active_high), .ir_tx_out(ir_tx_out)
);

// File: tb/strap_pad_ctrl_test.sv
module strap_pad_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pad_in = 2'b00;
  logic [1:0] addr_bits = 2'b00;
  logic       cpu_idle = 1'b0, irq2_active = 1'b0, sleep_req = 1'b0, ir_tx_raw = 1'b0;
  logic [1:0] pad_oe, pad_do, pad_pu, pad_pd;
  logic       ext_clk_mode, ir_active_high, ir_tx_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  strap_pad_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .addr_bits(addr_bits),
    .cpu_idle(cpu_idle), .irq2_active(irq2_active), .sleep_req(sleep_req),
    .ir_tx_raw(ir_tx_raw), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .ext_clk_mode(ext_clk_mode), .ir_active_high(ir_active_high),
    .ir_tx_out(ir_tx_out)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      logic [1:0] strap = 2'(c);
      @(negedge clk);
      rst_n  = 1'b0;
      pad_in = strap;
      addr_bits = 2'b11;
      repeat (4) @(negedge clk);
      #5;
      check("R1 oe/do in reset", {pad_oe, pad_do}, 4'h0);
      check("R2 pulls in reset", {pad_pu, pad_pd}, 4'b0110);
      @(negedge clk);
      rst_n  = 1'b1;
      @(negedge clk);
      pad_in = ~strap;
      repeat (3) @(negedge clk);
      #5;
      check("R4/R10 captured straps", {2'b00, ext_clk_mode, ir_active_high}, {2'b00, strap});
      check("R5 pad change ignored", {2'b00, ext_clk_mode, ir_active_high}, {2'b00, strap});
      check("R6 clock mode", {3'b000, ext_clk_mode}, {3'b000, strap[1]});
      for (int v = 0; v < 16; v++) begin
        logic [3:0] bits = 4'(v);
        logic       park;
        logic [1:0] eoe;
        @(negedge clk);
        {cpu_idle, irq2_active, sleep_req, ir_tx_raw} = bits;
        addr_bits = 2'(v + c);
        #5;
        park = strap[1] && bits[3] && !bits[2] && bits[1];
        eoe  = park ? 2'b01 : 2'b11;
        check("R3 pulls off, data", {pad_pu, pad_pd}, 4'h0);
        check("R3 pad data", {2'b00, pad_do}, {2'b00, 2'(v + c)});
        if (strap[1]) check("R8 park", {2'b00, pad_oe}, {2'b00, eoe});
        else          check("R7 no park", {2'b00, pad_oe}, 4'b0011);
        check("R9 ir polarity", {3'b000, ir_tx_out},
              {3'b000, strap[0] ? bits[0] : ~bits[0]});
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule